// File: doc/BRIEF.md
# Floating-Point Set-on-Compare Unit

This unit compares two IEEE-754 values and records whether a chosen relation holds in a one-bit status flag (`fpsr_bit`). A request gives both operands, a precision select and a 3-bit predicate code. A single-precision operand is one 32-bit register. A double-precision operand is an even/odd register pair: the even register holds the upper word (sign, exponent, high fraction) and the odd register holds the lower word. Both operands of a request use the same precision. The caller also passes the two source register numbers, so that the unit can reject a double-precision request that names an odd register.

The flag is registered. It takes the result on the clock edge after an accepted request and otherwise keeps its value. A small controller tracks what happened in the previous cycle. It has three states:
- `ST_IDLE`: no request was taken.
- `ST_WRITTEN`: a request was accepted and the flag was loaded.
- `ST_REJECTED`: a double-precision request named an odd register. The flag was left alone and `bad_operand` is raised.

Every state can move to any of the three on each cycle:
- A legal request moves to `ST_WRITTEN` (transition *accept*).
- An illegal request moves to `ST_REJECTED` (transition *reject*).
- No request moves to `ST_IDLE` (transition *rest*).
- Reset moves to `ST_IDLE`.

Top module: `fcmp_setcc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `fpsr_bit` is 0 and `bad_operand` is 0.
- R2: Predicate codes are LT=0, GT=1, EQ=2, LE=3, GE=4, NE=5. For two ordered (non-NaN) operands, `fpsr_bit` becomes 1 when `a <pred> b` holds and 0 when it does not.
- R3: In single precision (`is_dbl`=0), only `a_hi` and `b_hi` are used. The sign is in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0. `a_lo` and `b_lo` have no effect on the result.
- R4: In double precision (`is_dbl`=1), the operand is `{x_hi, x_lo}`. The sign is in bit 63, the exponent in bits 62:52 and the fraction in bits 51:0. A difference only in the low word changes the ordering.
- R5: +0 and -0 compare equal in both precisions. EQ, LE and GE give 1, and LT, GT and NE give 0.
- R6: A NaN is an all-ones exponent with a non-zero fraction. If either operand is a NaN, predicates 0 to 4 give 0 and NE gives 1.
- R7: `fpsr_bit` takes the result of an accepted request on the next rising edge. In a cycle with `req_valid` low it keeps its value.
- R8: A double-precision request with an odd `ra_idx` or `rb_idx` is rejected. `bad_operand` is 1 in the following cycle and `fpsr_bit` keeps its value.
- R9: Predicate codes 6 and 7 are accepted and write 0 to `fpsr_bit`.
- R10: Single-precision requests are legal for any register numbers, odd or even.
- R11: `bad_operand` is 1 for exactly the cycle after a rejected request. It is 0 after any cycle that holds no request or a legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Compare request present this cycle |
| is_dbl | input | 1 | 1 = double precision, 0 = single precision |
| pred_code | input | 3 | Relation select (LT, GT, EQ, LE, GE, NE = 0 to 5) |
| ra_idx | input | 5 | Register number of operand a |
| rb_idx | input | 5 | Register number of operand b |
| a_hi | input | 32 | Operand a: single value, or upper word of a double |
| a_lo | input | 32 | Operand a: lower word of a double |
| b_hi | input | 32 | Operand b: single value, or upper word of a double |
| b_lo | input | 32 | Operand b: lower word of a double |
| fpsr_bit | output | 1 | Registered compare result flag |
| bad_operand | output | 1 | Previous request was rejected for an odd register pair |

## Verification
Uniform random words almost never produce the cases that decide correctness. These cases are NaNs, infinities, signed zeros, and double values whose upper words match so that the low word decides the order. The stimulus therefore draws each operand from a pool that is weighted toward these encodings. It often makes operand b a copy of a, a sign-flipped copy, or a copy with only the low word changed. The hardest sequence is a rejected request that follows a written result, because the flag must survive untouched. To reach it, accepted and rejected double requests are interleaved on consecutive cycles while a behavioural model tracks the expected flag on every clock.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int FC_REG_W     = 32;
    localparam int FC_SP_EXP_W  = 8;
    localparam int FC_SP_FRAC_W = 23;
    localparam int FC_DP_EXP_W  = 11;
    localparam int FC_DP_FRAC_W = 52;
    localparam int FC_MAG_W     = FC_DP_EXP_W + FC_DP_FRAC_W;

    typedef enum logic [2:0] {
        PRED_LT   = 3'd0,
        PRED_GT   = 3'd1,
        PRED_EQ   = 3'd2,
        PRED_LE   = 3'd3,
        PRED_GE   = 3'd4,
        PRED_NE   = 3'd5,
        PRED_RSV6 = 3'd6,
        PRED_RSV7 = 3'd7
    } pred_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WRITTEN  = 2'd1,
        ST_REJECTED = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic                sign;
        logic                nan;
        logic                zero;
        logic [FC_MAG_W-1:0] mag;
    } opnd_t;

endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int REG_W     = FC_REG_W,
    parameter int SP_EXP_W  = FC_SP_EXP_W,
    parameter int SP_FRAC_W = FC_SP_FRAC_W,
    parameter int DP_EXP_W  = FC_DP_EXP_W,
    parameter int DP_FRAC_W = FC_DP_FRAC_W
) (
    input  logic             is_dbl,
    input  logic [REG_W-1:0] word_hi,
    input  logic [REG_W-1:0] word_lo,
    output opnd_t            fields
);
    localparam int PAIR_W = 2 * REG_W;
    localparam int MAG_W  = DP_EXP_W + DP_FRAC_W;

    logic [PAIR_W-1:0]    pair;
    logic [DP_EXP_W-1:0]  d_exp;
    logic [DP_FRAC_W-1:0] d_frac;
    logic [SP_EXP_W-1:0]  s_exp;
    logic [SP_FRAC_W-1:0] s_frac;

    always_comb begin
        pair   = {word_hi, word_lo};
        d_exp  = pair[PAIR_W-2 -: DP_EXP_W];
        d_frac = pair[DP_FRAC_W-1:0];
        s_exp  = word_hi[REG_W-2 -: SP_EXP_W];
        s_frac = word_hi[SP_FRAC_W-1:0];
        if (is_dbl) begin
            fields.sign = pair[PAIR_W-1];
            fields.nan  = (&d_exp) && (|d_frac);
            fields.mag  = pair[MAG_W-1:0];
        end else begin
            fields.sign = word_hi[REG_W-1];
            fields.nan  = (&s_exp) && (|s_frac);
            fields.mag  = MAG_W'(word_hi[REG_W-2:0]);
        end
        fields.zero = (fields.mag == '0);
    end

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t opa,
    input  opnd_t opb,
    input  pred_e pred,
    output logic  hit
);
    logic unordered;
    logic both_zero;
    logic is_eq;
    logic is_lt;

    always_comb begin
        unordered = opa.nan | opb.nan;
        both_zero = opa.zero & opb.zero;
        is_eq     = both_zero | ((opa.sign == opb.sign) && (opa.mag == opb.mag));
        if (both_zero)
            is_lt = 1'b0;
        else if (opa.sign != opb.sign)
            is_lt = opa.sign;
        else if (opa.sign)
            is_lt = opa.mag > opb.mag;
        else
            is_lt = opa.mag < opb.mag;

        unique case (pred)
            PRED_LT: hit = ~unordered & is_lt;
            PRED_GT: hit = ~unordered & ~is_lt & ~is_eq;
            PRED_EQ: hit = ~unordered & is_eq;
            PRED_LE: hit = ~unordered & (is_lt | is_eq);
            PRED_GE: hit = ~unordered & ~is_lt;
            PRED_NE: hit = unordered | ~is_eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
    import fcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic reject,
    input  logic hit,
    output logic fpsr_bit,
    output logic bad_operand
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WRITTEN, ST_REJECTED: begin
                if (!req_valid)
                    state_d = ST_IDLE;
                else if (reject)
                    state_d = ST_REJECTED;
                else
                    state_d = ST_WRITTEN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fpsr_bit <= 1'b0;
        else if (state_d == ST_WRITTEN)
            fpsr_bit <= hit;
    end

    assign bad_operand = (state_q == ST_REJECTED);

endmodule

// File: rtl/fcmp_setcc.sv
module fcmp_setcc
    import fcmp_pkg::*;
#(
    parameter int REG_W  = FC_REG_W,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_dbl,
    input  logic [2:0]        pred_code,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    input  logic [REG_W-1:0]  a_hi,
    input  logic [REG_W-1:0]  a_lo,
    input  logic [REG_W-1:0]  b_hi,
    input  logic [REG_W-1:0]  b_lo,
    output logic              fpsr_bit,
    output logic              bad_operand
);
    localparam int N_OPND = 2;

    logic [REG_W-1:0] hi_w [N_OPND];
    logic [REG_W-1:0] lo_w [N_OPND];
    opnd_t            op_f [N_OPND];
    logic             reject;
    logic             hit;

    assign hi_w[0] = a_hi;
    assign hi_w[1] = b_hi;
    assign lo_w[0] = a_lo;
    assign lo_w[1] = b_lo;

    assign reject = is_dbl & (ra_idx[0] | rb_idx[0]);

    for (genvar g = 0; g < N_OPND; g++) begin : g_unpack
        fcmp_unpack #(.REG_W(REG_W)) unpack_i (
            .is_dbl  (is_dbl),
            .word_hi (hi_w[g]),
            .word_lo (lo_w[g]),
            .fields  (op_f[g])
        );
    end

    fcmp_relate relate_i (
        .opa  (op_f[0]),
        .opb  (op_f[1]),
        .pred (pred_e'(pred_code)),
        .hit  (hit)
    );

    fcmp_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .reject      (reject),
        .hit         (hit),
        .fpsr_bit    (fpsr_bit),
        .bad_operand (bad_operand)
    );

endmodule

// File: rtl/fcmp_setcc_chk.sv
module fcmp_setcc_chk #(
    parameter int REG_W  = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              is_dbl,
    input logic [2:0]        pred_code,
    input logic [RIDX_W-1:0] ra_idx,
    input logic [RIDX_W-1:0] rb_idx,
    input logic [REG_W-1:0]  a_hi,
    input logic [REG_W-1:0]  b_hi,
    input logic              fpsr_bit,
    input logic              bad_operand
);
    localparam int SP_EXP_W = 8;

    logic odd_pair;
    logic sp_a_nan;
    logic sp_zeros;

    assign odd_pair = is_dbl && (ra_idx[0] || rb_idx[0]);
    assign sp_a_nan = (&a_hi[REG_W-2 -: SP_EXP_W]) && (|a_hi[REG_W-SP_EXP_W-2:0]);
    assign sp_zeros = (a_hi[REG_W-2:0] == '0) && (b_hi[REG_W-2:0] == '0);

    // R7
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fpsr_bit) && !bad_operand);

    // R8
    p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && odd_pair |=> $stable(fpsr_bit) && bad_operand);

    // R11
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !odd_pair |=> !bad_operand);

    // R5
    p_zero_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !is_dbl && sp_zeros && pred_code == 3'd2 |=> fpsr_bit);

    // R6
    p_nan_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !is_dbl && sp_a_nan && pred_code < 3'd5 |=> !fpsr_bit);

    // R6
    p_nan_ne_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !is_dbl && sp_a_nan && pred_code == 3'd5 |=> fpsr_bit);

    // R9
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !odd_pair && pred_code[2:1] == 2'b11 |=> !fpsr_bit);

endmodule

bind fcmp_setcc fcmp_setcc_chk #(.REG_W(REG_W), .RIDX_W(RIDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .is_dbl      (is_dbl),
    .pred_code   (pred_code),
    .ra_idx      (ra_idx),
    .rb_idx      (rb_idx),
    .a_hi        (a_hi),
    .b_hi        (b_hi),
    .fpsr_bit    (fpsr_bit),
    .bad_operand (bad_operand)
);

// File: tb/fcmp_setcc_tb_top.sv
module fcmp_setcc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        is_dbl;
    logic [2:0]  pred_code;
    logic [4:0]  ra_idx, rb_idx;
    logic [31:0] a_hi, a_lo, b_hi, b_lo;
    logic        fpsr_bit, bad_operand;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  exp_fpsr = 0;
    bit  exp_bad = 0;

    always #4 clk = ~clk;

    fcmp_setcc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_dbl(is_dbl),
        .pred_code(pred_code), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .fpsr_bit(fpsr_bit), .bad_operand(bad_operand)
    );

    function automatic bit ref_rel(bit dbl, bit [2:0] p, bit [31:0] ah, bit [31:0] al,
                                   bit [31:0] bh, bit [31:0] bl);
        bit [63:0] va = {ah, al};
        bit [63:0] vb = {bh, bl};
        bit na, nb, sa, sb;
        bit [62:0] ma, mb;
        logic signed [65:0] ka, kb;
        if (dbl) begin
            na = (va[62:52] == 11'h7ff) && (va[51:0] != 0);
            nb = (vb[62:52] == 11'h7ff) && (vb[51:0] != 0);
            sa = va[63]; sb = vb[63];
            ma = va[62:0]; mb = vb[62:0];
        end else begin
            na = (ah[30:23] == 8'hff) && (ah[22:0] != 0);
            nb = (bh[30:23] == 8'hff) && (bh[22:0] != 0);
            sa = ah[31]; sb = bh[31];
            ma = {32'd0, ah[30:0]}; mb = {32'd0, bh[30:0]};
        end
        ka = sa ? -$signed({3'b000, ma}) : $signed({3'b000, ma});
        kb = sb ? -$signed({3'b000, mb}) : $signed({3'b000, mb});
        if (p > 3'd5) return 1'b0;
        if (na || nb) return p == 3'd5;
        case (p)
            3'd0: return ka <  kb;
            3'd1: return ka >  kb;
            3'd2: return ka == kb;
            3'd3: return ka <= kb;
            3'd4: return ka >= kb;
            default: return ka != kb;
        endcase
    endfunction

    task automatic check(string tag, string what, bit act, bit expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Entered at a falling edge; leaves at the next falling edge after comparing.
    task automatic cyc(string tag, bit v, bit d, bit [2:0] p, bit [4:0] ra, bit [4:0] rb,
                       bit [31:0] ah, bit [31:0] al, bit [31:0] bh, bit [31:0] bl);
        req_valid = v; is_dbl = d; pred_code = p; ra_idx = ra; rb_idx = rb;
        a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl;
        @(posedge clk);
        if (v && d && (ra[0] || rb[0])) begin
            exp_bad = 1;
        end else if (v) begin
            exp_bad = 0;
            exp_fpsr = ref_rel(d, p, ah, al, bh, bl);
        end else begin
            exp_bad = 0;
        end
        @(negedge clk);
        check(tag, "fpsr_bit", fpsr_bit, exp_fpsr);
        check(tag, "bad_operand", bad_operand, exp_bad);
    endtask

    task automatic sp(string tag, bit [2:0] p, bit [31:0] a, bit [31:0] b);
        cyc(tag, 1, 0, p, 5'd2, 5'd4, a, 32'h0, b, 32'h0);
    endtask

    task automatic dp(string tag, bit [2:0] p, bit [63:0] a, bit [63:0] b);
        cyc(tag, 1, 1, p, 5'd2, 5'd6, a[63:32], a[31:0], b[63:32], b[31:0]);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 3'd0, 5'd0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    endtask

    function automatic bit [31:0] pick_sp();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7f80_0000;
            3: return 32'hff80_0000;
            4: return 32'h7fc0_0001;
            default: return $urandom;
        endcase
    endfunction

    function automatic bit [63:0] pick_dp();
        case ($urandom % 8)
            0: return 64'h0;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h7ff0_0000_0000_0000;
            3: return 64'hfff0_0000_0000_0000;
            4: return 64'h7ff0_0000_0000_0001;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; is_dbl = 0; pred_code = 0;
        ra_idx = 0; rb_idx = 0; a_hi = 0; a_lo = 0; b_hi = 0; b_lo = 0;
        repeat (3) @(negedge clk);
        check("R1", "fpsr_bit in reset", fpsr_bit, 1'b0);
        check("R1", "bad_operand in reset", bad_operand, 1'b0);
        rst_n = 1;
        idle("R1");

        // R2: ordered single-precision relations, every predicate
        for (int p = 0; p < 6; p++) begin
            sp("R2", 3'(p), 32'h3f80_0000, 32'h4000_0000);
            sp("R2", 3'(p), 32'h4000_0000, 32'h3f80_0000);
            sp("R2", 3'(p), 32'hbf80_0000, 32'hbf80_0000);
            sp("R2", 3'(p), 32'hbf80_0000, 32'h3f80_0000);
            sp("R2", 3'(p), 32'hc000_0000, 32'hbf80_0000);
            sp("R2", 3'(p), 32'hff80_0000, 32'h7f80_0000);
        end
        // R3: low words ignored in single precision
        cyc("R3", 1, 0, 3'd2, 5'd1, 5'd3, 32'h3f80_0000, 32'hffff_ffff, 32'h3f80_0000, 32'h0);
        cyc("R3", 1, 0, 3'd0, 5'd1, 5'd3, 32'h3f80_0000, 32'h0, 32'h3f80_0000, 32'h1234_5678);
        // R4: double precision, low word decides
        dp("R4", 3'd0, 64'h3ff0_0000_0000_0000, 64'h3ff0_0000_0000_0001);
        dp("R4", 3'd1, 64'h3ff0_0000_0000_0000, 64'h3ff0_0000_0000_0001);
        dp("R4", 3'd0, 64'hbff0_0000_0000_0000, 64'hbff0_0000_0000_0001);
        dp("R4", 3'd2, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000);
        // R5: signed zeros
        for (int p = 0; p < 6; p++) begin
            sp("R5", 3'(p), 32'h8000_0000, 32'h0000_0000);
            dp("R5", 3'(p), 64'h0, 64'h8000_0000_0000_0000);
        end
        // R6: NaN operands
        for (int p = 0; p < 6; p++) begin
            sp("R6", 3'(p), 32'h7fc0_0000, 32'h3f80_0000);
            sp("R6", 3'(p), 32'h3f80_0000, 32'hff80_0001);
            dp("R6", 3'(p), 64'h7ff8_0000_0000_0000, 64'h7ff8_0000_0000_0000);
            dp("R6", 3'(p), 64'h0, 64'h7ff0_0000_0000_0001);
        end
        // R7: hold across idle cycles after a 1
        sp("R7", 3'd5, 32'h3f80_0000, 32'h4000_0000);
        idle("R7"); idle("R7");
        sp("R7", 3'd2, 32'h3f80_0000, 32'h4000_0000);
        idle("R7");
        // R8 and R11: rejection keeps the flag, then clears
        sp("R8", 3'd4, 32'h4000_0000, 32'h3f80_0000);
        cyc("R8", 1, 1, 3'd2, 5'd3, 5'd4, 32'h0, 32'h0, 32'h3ff0_0000, 32'h0);
        cyc("R8", 1, 1, 3'd2, 5'd2, 5'd5, 32'h0, 32'h0, 32'h3ff0_0000, 32'h0);
        idle("R11");
        cyc("R8", 1, 1, 3'd2, 5'd7, 5'd9, 32'h0, 32'h0, 32'h3ff0_0000, 32'h0);
        dp("R11", 3'd0, 64'h0, 64'h3ff0_0000_0000_0000);
        // R9: reserved codes
        sp("R9", 3'd6, 32'h3f80_0000, 32'h4000_0000);
        sp("R5", 3'd4, 32'h0, 32'h0);
        sp("R9", 3'd7, 32'h7fc0_0000, 32'h0);
        // R10: odd registers legal in single precision
        cyc("R10", 1, 0, 3'd0, 5'd3, 5'd7, 32'h3f80_0000, 32'h0, 32'h4000_0000, 32'h0);
        cyc("R10", 1, 0, 3'd1, 5'd31, 5'd1, 32'h3f80_0000, 32'h0, 32'h4000_0000, 32'h0);

        // Mixed random traffic (R2 R4 R6 R8 R11)
        for (int i = 0; i < 1500; i++) begin
            int kind = $urandom % 10;
            bit [2:0] p = 3'($urandom);
            bit [4:0] ra = 5'($urandom);
            bit [4:0] rb = 5'($urandom);
            if (kind == 0) begin
                idle("R7");
            end else if (kind < 5) begin
                bit [31:0] a = pick_sp();
                bit [31:0] b;
                case ($urandom % 3)
                    0: b = a;
                    1: b = a ^ 32'h8000_0000;
                    default: b = pick_sp();
                endcase
                cyc("R2", 1, 0, p, ra, rb, a, $urandom, b, $urandom);
            end else begin
                bit [63:0] a = pick_dp();
                bit [63:0] b;
                case ($urandom % 3)
                    0: b = {a[63:32], $urandom};
                    1: b = a ^ 64'h8000_0000_0000_0000;
                    default: b = pick_dp();
                endcase
                if ($urandom % 3 != 0) begin
                    ra[0] = 0; rb[0] = 0;
                end
                cyc("R4", 1, 1, p, ra, rb, a[63:32], a[31:0], b[63:32], b[31:0]);
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule